// File: doc/BRIEF.md
# Microcoded Register-ALU Network

This block is the compute stage that holds one data page at a time. A page consists of four working variables (A, B, C, D), four freshly acquired samples (one for each variable) and a small state key. The page arrives in a single cycle on a wide parallel port. A stream of 12-bit microwords then reconfigures the network. Each accepted word updates the page in one clock. The updated variables and key are always visible on parallel outputs, so the next stage can take the page when the sequence ends.

Every variable has its own ALU. The wiring is sparse on purpose. Variable A may read any sample, any other variable or its own auxiliary copy. Each of B, C and D may read only its own sample, its own auxiliary copy and the variable just below it. A single word names a set of destination variables and applies one function to all of them at once. Transition words compare A with B and write the next-state value into the key. A set of auxiliary registers (one per variable, plus a key copy) is not part of the page. It keeps its contents when a new page is loaded, so one page can leave values there for the pages that follow. A variable that exchanges itself with its auxiliary copy in every page therefore moves values one page along the sequence.

Top module: `reg_alu_net`

## Requirements
- R1: After reset, all variables, samples, the key, the auxiliary variables and the auxiliary key are zero.
- R2: When `page_ld_i` is high, the variables, samples and key take the load port values at the next edge. An accepted microword in the same cycle is discarded.
- R3: Microword layout: bits [11:10] are the prefix, [9:7] the root, [6:4] the specifier and [3:0] the destination mask (bit 0 = A, bit 3 = D). A variable whose mask bit is clear keeps its value. A cycle with no valid word and no load changes nothing.
- R4: Operand select. For A, specifier 0–3 selects sample A–D, 4–6 selects variable B–D and 7 selects auxiliary A. For B, C and D, specifier[1:0] = 0 selects the variable's own sample, 1 its own auxiliary copy, and 2 or 3 the variable one below it (A for B, B for C, C for D).
- R5: Roots 0 to 5 are, in order, move, add, subtract, AND, OR and XOR, each computed as destination op operand.
- R6: Prefix bit 0 = 1 makes add and increment stick at 0xFFFF and makes subtract and decrement stick at 0. With the bit clear, these operations wrap modulo 2^16.
- R7: All destinations named by one word compute from the register values held before that edge.
- R8: Root 6 is unary, with the specifier choosing the operation: 0 clear, 1 increment, 2 decrement, 3 invert, 4 shift left by one, 5 logical shift right by one, 6 exchange with the auxiliary copy, 7 hold.
- R9: A unary exchange swaps each named variable with its auxiliary copy in one step.
- R10: Root 7 with specifier 0 is a chain shift over the named variables: A takes sample A, B takes the old A, C takes the old B and D takes the old C.
- R11: Root 7 with specifier bit 2 set is a transition. The prefix selects the unsigned relation of A to B (00 equal, 01 not equal, 10 less than, 11 greater or equal). If the relation holds, the key becomes {specifier[1:0], mask}. Otherwise the key is unchanged.
- R12: Root 7 with specifier 2 copies the key into the auxiliary key. Root 7 with specifier 3 copies the auxiliary key into the key.
- R13: Page loads leave the auxiliary variables and the auxiliary key unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| page_ld_i | input | 1 | Load a new page this cycle |
| ld_var_i | input | 64 | Variables A..D to load, A in bits [15:0] |
| ld_smp_i | input | 64 | Samples A..D to load, A in bits [15:0] |
| ld_key_i | input | 6 | Key to load |
| uw_valid_i | input | 1 | Microword valid |
| uw_i | input | 12 | Microword |
| var_o | output | 64 | Current variables A..D, A in bits [15:0] |
| key_o | output | 6 | Current key |
| aux_o | output | 64 | Auxiliary variables A..D |
| auxkey_o | output | 6 | Auxiliary key |

## Verification
Two pages are run through words that each target several variables at once. Overlapping destinations, such as B+A, C+B and D+C in one word, or the chain shift, show whether each operand is sampled before the step or after it. Add and subtract are driven near both ends of the range with the prefix bit set and then cleared, which separates sticking at a limit from wrapping. Transitions are tried with relations that hold and with relations that fail, and the auxiliary contents are followed across a second and third page load to confirm they persist. An idle cycle, an empty mask and a load that coincides with a word check that nothing changes when it should not.

// File: rtl/reg_alu_net_pkg.sv
package reg_alu_net_pkg;

    localparam int DW = 16;        // data width
    localparam int NV = 4;         // variables per page
    localparam int UW = 12;        // microword width
    localparam int KW = NV + 2;    // key width = target field of a transition

    typedef logic [DW-1:0] word_t;
    typedef logic [KW-1:0] key_t;

    typedef enum logic [2:0] {
        RT_MOV, RT_ADD, RT_SUB, RT_AND, RT_OR, RT_XOR, RT_UNARY, RT_SPECIAL
    } root_e;

    localparam logic [2:0] UN_CLR  = 3'd0;
    localparam logic [2:0] UN_INC  = 3'd1;
    localparam logic [2:0] UN_DEC  = 3'd2;
    localparam logic [2:0] UN_NOT  = 3'd3;
    localparam logic [2:0] UN_SHL  = 3'd4;
    localparam logic [2:0] UN_SHR  = 3'd5;
    localparam logic [2:0] UN_SWAP = 3'd6;

    localparam logic [2:0] SP_CHAIN = 3'd0;
    localparam logic [2:0] SP_PUB   = 3'd2;
    localparam logic [2:0] SP_ADOPT = 3'd3;

    typedef struct packed {
        logic [1:0]    pfx;
        root_e         root;
        logic [2:0]    spec;
        logic [NV-1:0] mask;
    } uword_t;

    localparam word_t W_ONE = word_t'(1);

    function automatic word_t add_lim(word_t a, word_t b, logic stick);
        logic [DW:0] s;
        s = {1'b0, a} + {1'b0, b};
        return (s[DW] && stick) ? '1 : s[DW-1:0];
    endfunction

    function automatic word_t sub_lim(word_t a, word_t b, logic stick);
        return (a < b && stick) ? '0 : word_t'(a - b);
    endfunction

endpackage

// File: rtl/reg_alu_net_lane.sv
module reg_alu_net_lane
    import reg_alu_net_pkg::*;
(
    input  uword_t cw,
    input  logic   sel,
    input  word_t  cur,
    input  word_t  opnd,
    input  word_t  chain_in,
    input  word_t  aux_cur,
    output word_t  nxt_var,
    output word_t  nxt_aux
);

    always_comb begin
        nxt_var = cur;
        nxt_aux = aux_cur;
        if (sel) begin
            case (cw.root)
                RT_MOV: nxt_var = opnd;
                RT_ADD: nxt_var = add_lim(cur, opnd, cw.pfx[0]);
                RT_SUB: nxt_var = sub_lim(cur, opnd, cw.pfx[0]);
                RT_AND: nxt_var = cur & opnd;
                RT_OR:  nxt_var = cur | opnd;
                RT_XOR: nxt_var = cur ^ opnd;
                RT_UNARY: begin
                    case (cw.spec)
                        UN_CLR:  nxt_var = '0;
                        UN_INC:  nxt_var = add_lim(cur, W_ONE, cw.pfx[0]);
                        UN_DEC:  nxt_var = sub_lim(cur, W_ONE, cw.pfx[0]);
                        UN_NOT:  nxt_var = ~cur;
                        UN_SHL:  nxt_var = cur << 1;
                        UN_SHR:  nxt_var = cur >> 1;
                        UN_SWAP: begin
                            nxt_var = aux_cur;
                            nxt_aux = cur;
                        end
                        default: nxt_var = cur;
                    endcase
                end
                RT_SPECIAL: begin
                    if (cw.spec == SP_CHAIN) nxt_var = chain_in;
                end
                default: nxt_var = cur;
            endcase
        end
    end

endmodule

// File: rtl/reg_alu_net_key.sv
module reg_alu_net_key
    import reg_alu_net_pkg::*;
(
    input  uword_t cw,
    input  word_t  va,
    input  word_t  vb,
    input  key_t   key,
    input  key_t   kaux,
    output key_t   nxt_key,
    output key_t   nxt_kaux
);

    logic rel_ok;

    always_comb begin
        case (cw.pfx)
            2'b00:   rel_ok = (va == vb);
            2'b01:   rel_ok = (va != vb);
            2'b10:   rel_ok = (va < vb);
            default: rel_ok = (va >= vb);
        endcase
    end

    always_comb begin
        nxt_key  = key;
        nxt_kaux = kaux;
        if (cw.root == RT_SPECIAL) begin
            if (cw.spec[2]) begin
                if (rel_ok) nxt_key = {cw.spec[1:0], cw.mask};
            end else if (cw.spec == SP_PUB) begin
                nxt_kaux = key;
            end else if (cw.spec == SP_ADOPT) begin
                nxt_key = kaux;
            end
        end
    end

endmodule

// File: rtl/reg_alu_net.sv
module reg_alu_net
    import reg_alu_net_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             page_ld_i,
    input  logic [NV*DW-1:0] ld_var_i,
    input  logic [NV*DW-1:0] ld_smp_i,
    input  logic [KW-1:0]    ld_key_i,
    input  logic             uw_valid_i,
    input  logic [UW-1:0]    uw_i,
    output logic [NV*DW-1:0] var_o,
    output logic [KW-1:0]    key_o,
    output logic [NV*DW-1:0] aux_o,
    output logic [KW-1:0]    auxkey_o
);

    uword_t cw;
    assign cw = uword_t'(uw_i);

    word_t vr [NV];
    word_t sr [NV];
    word_t ar [NV];
    key_t  kr, kar;

    word_t opnd  [NV];
    word_t chin  [NV];
    word_t nv    [NV];
    word_t na    [NV];
    key_t  nk, nka;

    for (genvar i = 0; i < NV; i++) begin : g_lane
        if (i == 0) begin : g_full
            always_comb begin
                case (cw.spec)
                    3'd0, 3'd1, 3'd2, 3'd3: opnd[i] = sr[cw.spec[1:0]];
                    3'd4:    opnd[i] = vr[1];
                    3'd5:    opnd[i] = vr[2];
                    3'd6:    opnd[i] = vr[3];
                    default: opnd[i] = ar[0];
                endcase
            end
            assign chin[i] = sr[0];
        end else begin : g_sparse
            always_comb begin
                case (cw.spec[1:0])
                    2'd0:    opnd[i] = sr[i];
                    2'd1:    opnd[i] = ar[i];
                    default: opnd[i] = vr[i-1];
                endcase
            end
            assign chin[i] = vr[i-1];
        end

        reg_alu_net_lane u_lane (
            .cw       (cw),
            .sel      (cw.mask[i]),
            .cur      (vr[i]),
            .opnd     (opnd[i]),
            .chain_in (chin[i]),
            .aux_cur  (ar[i]),
            .nxt_var  (nv[i]),
            .nxt_aux  (na[i])
        );

        assign var_o[i*DW +: DW] = vr[i];
        assign aux_o[i*DW +: DW] = ar[i];

        // R3: a variable outside the mask holds
        a_r3_unmasked_hold: assert property (@(posedge clk) disable iff (rst)
            (uw_valid_i && !page_ld_i && !cw.mask[i]) |=> $stable(var_o[i*DW +: DW]));
    end

    reg_alu_net_key u_key (
        .cw       (cw),
        .va       (vr[0]),
        .vb       (vr[1]),
        .key      (kr),
        .kaux     (kar),
        .nxt_key  (nk),
        .nxt_kaux (nka)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NV; i++) begin
                vr[i] <= '0;
                sr[i] <= '0;
                ar[i] <= '0;
            end
            kr  <= '0;
            kar <= '0;
        end else if (page_ld_i) begin
            for (int i = 0; i < NV; i++) begin
                vr[i] <= ld_var_i[i*DW +: DW];
                sr[i] <= ld_smp_i[i*DW +: DW];
            end
            kr <= ld_key_i;
        end else if (uw_valid_i) begin
            for (int i = 0; i < NV; i++) begin
                vr[i] <= nv[i];
                ar[i] <= na[i];
            end
            kr  <= nk;
            kar <= nka;
        end
    end

    assign key_o    = kr;
    assign auxkey_o = kar;

    a_r2_load_takes_page: assert property (@(posedge clk) disable iff (rst)
        page_ld_i |=> (var_o == $past(ld_var_i)) && (key_o == $past(ld_key_i)));

    a_r13_aux_survives_load: assert property (@(posedge clk) disable iff (rst)
        page_ld_i |=> $stable(aux_o) && $stable(auxkey_o));

    a_r3_idle_no_change: assert property (@(posedge clk) disable iff (rst)
        (!page_ld_i && !uw_valid_i) |=>
            $stable(var_o) && $stable(key_o) && $stable(aux_o) && $stable(auxkey_o));

    a_r6_sticky_add_no_drop: assert property (@(posedge clk) disable iff (rst)
        (uw_valid_i && !page_ld_i && cw.root == RT_ADD && cw.pfx[0] && cw.mask[0])
            |=> var_o[DW-1:0] >= $past(var_o[DW-1:0]));

    a_r11_failed_eq_keeps_key: assert property (@(posedge clk) disable iff (rst)
        (uw_valid_i && !page_ld_i && cw.root == RT_SPECIAL && cw.spec[2] &&
         cw.pfx == 2'b00 && var_o[DW-1:0] != var_o[2*DW-1:DW]) |=> $stable(key_o));

endmodule

// File: tb/reg_alu_net_bench.sv
module reg_alu_net_bench;
    import reg_alu_net_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             page_ld_i = 1'b0;
    logic [NV*DW-1:0] ld_var_i = '0;
    logic [NV*DW-1:0] ld_smp_i = '0;
    logic [KW-1:0]    ld_key_i = '0;
    logic             uw_valid_i = 1'b0;
    logic [UW-1:0]    uw_i = '0;
    logic [NV*DW-1:0] var_o, aux_o;
    logic [KW-1:0]    key_o, auxkey_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_alu_net u_reg_alu_net (
        .clk(clk), .rst(rst), .page_ld_i(page_ld_i), .ld_var_i(ld_var_i),
        .ld_smp_i(ld_smp_i), .ld_key_i(ld_key_i), .uw_valid_i(uw_valid_i),
        .uw_i(uw_i), .var_o(var_o), .key_o(key_o), .aux_o(aux_o), .auxkey_o(auxkey_o)
    );

    typedef logic [2*NV*DW+2*KW-1:0] snap_t;

    int    n_chk = 0;
    int    n_bad = 0;
    snap_t exp_q [$];
    string tag_q [$];

    // expected shadow state, set by hand before each step
    logic [15:0] ea, eb, ec, ed, xa, xb, xc, xd;
    logic [5:0]  ek, exk;

    function automatic logic [11:0] mw(input logic [1:0] p, input logic [2:0] r,
                                       input logic [2:0] s, input logic [3:0] m);
        return {p, r, s, m};
    endfunction

    function automatic snap_t exp_snap();
        return {ed, ec, eb, ea, ek, xd, xc, xb, xa, exk};
    endfunction

    task automatic check_now(input snap_t e, input string tag);
        snap_t got;
        got = {var_o, key_o, aux_o, auxkey_o};
        n_chk++;
        if (got !== e) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, e);
        end
    endtask

    task automatic step(input logic ld, input logic v, input logic [11:0] w, input string tag);
        @(negedge clk);
        page_ld_i  = ld;
        uw_valid_i = v;
        uw_i       = w;
        exp_q.push_back(exp_snap());
        tag_q.push_back(tag);
    endtask

    // monitor: pops one expected snapshot per driven cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && exp_q.size() > 0) begin
                snap_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check_now(e, t);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        ea = 0; eb = 0; ec = 0; ed = 0; xa = 0; xb = 0; xc = 0; xd = 0; ek = 0; exk = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_now(exp_snap(), "R1 reset state");

        // page 1
        ld_var_i = {16'd40, 16'd30, 16'd20, 16'd10};
        ld_smp_i = {16'd4, 16'd3, 16'd2, 16'd1};
        ld_key_i = 6'd5;
        ea = 10; eb = 20; ec = 30; ed = 40; ek = 5;
        step(1, 0, '0, "R2 page load");
        ea = 1; eb = 2;
        step(0, 1, mw(2'b00, 3'd0, 3'd0, 4'b0011), "R4 move sample into A and B");
        eb = 3; ec = 32; ed = 70;
        step(0, 1, mw(2'b00, 3'd1, 3'd2, 4'b1110), "R7 add neighbour, old values");
        ea = 0; xa = 1; ec = 0; xc = 32;
        step(0, 1, mw(2'b00, 3'd6, 3'd6, 4'b0101), "R9 exchange with aux");
        exk = 5;
        step(0, 1, mw(2'b00, 3'd7, 3'd2, 4'b0000), "R12 publish key");

        // page 2
        ld_var_i = {16'd7, 16'd5, 16'h0020, 16'hFFF0};
        ld_smp_i = {16'd3, 16'd2, 16'd1, 16'h0030};
        ld_key_i = 6'd9;
        ea = 16'hFFF0; eb = 16'h0020; ec = 5; ed = 7; ek = 9;
        step(1, 0, '0, "R13 aux kept across load");
        ea = 16'hFFFF;
        step(0, 1, mw(2'b01, 3'd1, 3'd0, 4'b0001), "R6 sticky add");
        ea = 16'h002F;
        step(0, 1, mw(2'b00, 3'd1, 3'd0, 4'b0001), "R6 wrapping add");
        eb = 16'h0000;
        step(0, 1, mw(2'b01, 3'd2, 3'd2, 4'b0010), "R6 sticky subtract");
        ec = 16'hFFE5;
        step(0, 1, mw(2'b00, 3'd2, 3'd1, 4'b0100), "R6 wrapping subtract from aux");
        ed = 16'd4;
        step(0, 1, mw(2'b00, 3'd5, 3'd0, 4'b1000), "R5 xor own sample");
        ea = 16'd1;
        step(0, 1, mw(2'b00, 3'd0, 3'd7, 4'b0001), "R4 A reads aux A");
        ea = 16'h0030; eb = 16'd1; ec = 16'd0; ed = 16'hFFE5;
        step(0, 1, mw(2'b00, 3'd7, 3'd0, 4'b1111), "R10 chain shift");
        ek = 6'd35;
        step(0, 1, mw(2'b11, 3'd7, 3'd6, 4'b0011), "R11 transition taken");
        step(0, 1, mw(2'b00, 3'd7, 3'd7, 4'b1111), "R11 transition not taken");
        ek = 6'd23;
        step(0, 1, mw(2'b01, 3'd7, 3'd5, 4'b0111), "R11 not-equal taken");
        ek = 6'd5;
        step(0, 1, mw(2'b00, 3'd7, 3'd3, 4'b0000), "R12 adopt aux key");
        step(0, 0, mw(2'b00, 3'd1, 3'd0, 4'b1111), "R3 idle cycle");
        step(0, 1, mw(2'b00, 3'd1, 3'd0, 4'b0000), "R3 empty mask");
        eb = 16'd2; ed = 16'hFFE6;
        step(0, 1, mw(2'b00, 3'd6, 3'd1, 4'b1010), "R8 increment");
        ec = 16'hFFFF;
        step(0, 1, mw(2'b00, 3'd6, 3'd3, 4'b0100), "R8 invert");
        step(0, 1, mw(2'b01, 3'd6, 3'd1, 4'b0100), "R6 sticky increment");
        ea = 16'h0018;
        step(0, 1, mw(2'b00, 3'd6, 3'd5, 4'b0001), "R8 shift right");

        // page 3 with a word in the same cycle
        ld_var_i = {16'd4, 16'd3, 16'd2, 16'd1};
        ld_smp_i = '0;
        ld_key_i = 6'd7;
        ea = 1; eb = 2; ec = 3; ed = 4; ek = 7;
        step(1, 1, mw(2'b00, 3'd0, 3'd0, 4'b1111), "R2 load beats word");
        ea = 0;
        step(0, 1, mw(2'b00, 3'd3, 3'd4, 4'b0001), "R5 and with B");
        ed = 7;
        step(0, 1, mw(2'b00, 3'd4, 3'd2, 4'b1000), "R5 or with C");

        @(negedge clk);
        page_ld_i = 0;
        uw_valid_i = 0;
        repeat (3) @(negedge clk);
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule